// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

This block fans up to 64 device interrupt lines out to up to four processors. All device requests land in one shared raw request word. Each processor owns a mask word. Its pending view is the bitwise AND of its mask and the shared raw word. Each processor receives a single level interrupt, which is asserted while any of its pending bits is set.

Devices drive single-cycle pulses to post or withdraw a request, and each pulse carries a line number. Software uses a simple 64-bit register port. A request pulse carries a write flag, a byte offset, a size code and write data. One cycle later the block answers with read data and an error flag. The register index is the byte offset divided by 64. A mask write takes effect at once: the same edge raises or drops the pending bits that the write unmasks or masks.

A parameter sets how many processors are populated. Mask writes aimed at a slot above that count are dropped.

Top module: `irq_router`

## Requirements
- R1: After reset every mask word and the raw request word are zero, every `cpu_irq` bit is low, and `rsp_valid` is low until the first access.
- R2: A write with size code 3 (8 bytes) to byte offset 64*c, for c below ACTIVE_CPUS, stores the data in processor c's mask. A read of that offset returns the mask on `rsp_rdata`, with `rsp_valid` high, in the cycle after the request.
- R3: A read of byte offset 64*(MAX_CPUS+c) returns processor c's pending word, which equals its mask AND the raw request word.
- R4: A post pulse on line N sets bit N of the raw request word. A read of byte offset 64*(2*MAX_CPUS) returns that word.
- R5: A clear pulse on line N zeroes raw bit N. A clear of a line whose raw bit is already zero changes nothing.
- R6: When a post and a clear name the same line in the same cycle, the clear wins and the bit ends at zero. When they name different lines, both take effect.
- R7: `cpu_irq[c]` is the OR of processor c's pending word, registered one cycle after the state changes. This holds for changes from a post, a clear, a mask write that unmasks an active line, and a mask write that masks one.
- R8: An access with any size code other than 3 sets `rsp_err`, returns zero read data and changes no state.
- R9: A write to a pending offset or to the raw request offset sets `rsp_err` and changes no state.
- R10: An access whose offset maps to no register, or whose low six offset bits are not zero, sets `rsp_err` and returns zero read data.
- R11: A mask write for a processor slot at or above ACTIVE_CPUS is dropped without error. That slot's mask reads zero and its `cpu_irq` bit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset from the block base |
| req_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 |
| req_wdata | input | DATA_W (64) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Illegal access flag |
| rsp_rdata | output | DATA_W (64) | Read data, zero on error or write |
| post_valid | input | 1 | Device request post pulse |
| post_line | input | LINE_W (6) | Line being posted |
| clr_valid | input | 1 | Device request clear pulse |
| clr_line | input | LINE_W (6) | Line being cleared |
| cpu_irq | output | MAX_CPUS (4) | Per-processor interrupt level |

## Verification
The assertions assume that post and clear pulses carry in-range line numbers. They also assume that only registered state feeds the interrupt outputs, so any change to the raw or mask words shows on `cpu_irq` exactly one edge later. The response checks assume `req_valid` is low throughout reset. The bench drives every input on the falling edge and holds requests low during reset. It uses only line numbers below 64, and it models the raw and mask words itself to predict every read and interrupt level.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PEND = 2'd2,
    SEL_RAW  = 2'd3
  } reg_sel_e;

  localparam int STRIDE_BITS = 6;

endpackage

// File: rtl/irq_access_decode.sv
module irq_access_decode
  import irq_router_pkg::*;
#(
  parameter int MAX_CPUS = 4,
  parameter int ADDR_W   = 12,
  localparam int CPU_W   = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int IDX_W   = ADDR_W - STRIDE_BITS
) (
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  output logic [MAX_CPUS-1:0] mask_we,
  output reg_sel_e            sel_kind,
  output logic [CPU_W-1:0]    sel_cpu,
  output logic                acc_err
);

  localparam logic [IDX_W-1:0] MASK_END = IDX_W'(MAX_CPUS);
  localparam logic [IDX_W-1:0] PEND_END = IDX_W'(2 * MAX_CPUS);
  localparam logic [IDX_W-1:0] RAW_IDX  = IDX_W'(2 * MAX_CPUS);

  logic [IDX_W-1:0]       idx;
  logic [STRIDE_BITS-1:0] sub;
  logic                   bad_shape;

  assign idx       = req_addr[ADDR_W-1:STRIDE_BITS];
  assign sub       = req_addr[STRIDE_BITS-1:0];
  assign bad_shape = (acc_size_e'(req_size) != SZ_DWORD) || (sub != '0);

  always_comb begin
    mask_we  = '0;
    sel_kind = SEL_NONE;
    sel_cpu  = '0;
    acc_err  = 1'b0;
    if (req_valid) begin
      if (bad_shape) begin
        acc_err = 1'b1;
      end else if (idx < MASK_END) begin
        sel_kind = SEL_MASK;
        sel_cpu  = CPU_W'(idx);
        if (req_write) begin
          mask_we = MAX_CPUS'(1) << CPU_W'(idx);
        end
      end else if (idx < PEND_END) begin
        sel_kind = SEL_PEND;
        sel_cpu  = CPU_W'(idx - MASK_END);
        acc_err  = req_write;
      end else if (idx == RAW_IDX) begin
        sel_kind = SEL_RAW;
        acc_err  = req_write;
      end else begin
        acc_err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 post_valid,
  input  logic [LINE_W-1:0]    post_line,
  input  logic                 clr_valid,
  input  logic [LINE_W-1:0]    clr_line,
  output logic [NUM_LINES-1:0] raw_q
);

  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] raw_d;
  logic                 raw_en;

  always_comb begin
    set_vec = post_valid ? (NUM_LINES'(1) << post_line) : '0;
    clr_vec = clr_valid  ? (NUM_LINES'(1) << clr_line)  : '0;
    // clear is applied after set, so it wins on a shared line
    raw_d   = (raw_q | set_vec) & ~clr_vec;
    raw_en  = post_valid | clr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int NUM_LINES = 64,
  parameter bit ENABLED   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic [NUM_LINES-1:0] raw_vec,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] pend,
  output logic                 irq_q
);

  logic                 mask_en;
  logic [NUM_LINES-1:0] mask_d;
  logic                 irq_d;

  always_comb begin
    mask_en = mask_we & ENABLED;
    mask_d  = mask_wdata;
    pend    = mask_q & raw_vec;
    irq_d   = |pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int MAX_CPUS    = 4,
  parameter int ACTIVE_CPUS = 4,
  parameter int NUM_LINES   = 64,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 12,
  localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CPU_W      = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic                post_valid,
  input  logic [LINE_W-1:0]   post_line,
  input  logic                clr_valid,
  input  logic [LINE_W-1:0]   clr_line,
  output logic [MAX_CPUS-1:0] cpu_irq
);

  logic                                rst_meta_q;
  logic                                rst_sync_n;
  logic [MAX_CPUS-1:0]                 mask_we;
  reg_sel_e                            sel_kind;
  logic [CPU_W-1:0]                    sel_cpu;
  logic                                acc_err;
  logic [NUM_LINES-1:0]                raw_vec;
  logic [MAX_CPUS-1:0][NUM_LINES-1:0]  mask_vec;
  logic [MAX_CPUS-1:0][NUM_LINES-1:0]  pend_vec;
  logic [NUM_LINES-1:0]                rd_word;
  logic [DATA_W-1:0]                   rdata_d;
  logic                                rvalid_d;
  logic                                rerr_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  irq_access_decode #(
    .MAX_CPUS (MAX_CPUS),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .mask_we   (mask_we),
    .sel_kind  (sel_kind),
    .sel_cpu   (sel_cpu),
    .acc_err   (acc_err)
  );

  irq_raw_bank #(
    .NUM_LINES (NUM_LINES)
  ) u_raw (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .post_valid (post_valid),
    .post_line  (post_line),
    .clr_valid  (clr_valid),
    .clr_line   (clr_line),
    .raw_q      (raw_vec)
  );

  for (genvar c = 0; c < MAX_CPUS; c++) begin : g_cpu
    irq_cpu_slice #(
      .NUM_LINES (NUM_LINES),
      .ENABLED   (c < ACTIVE_CPUS)
    ) u_slice (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .mask_we    (mask_we[c]),
      .mask_wdata (req_wdata[NUM_LINES-1:0]),
      .raw_vec    (raw_vec),
      .mask_q     (mask_vec[c]),
      .pend       (pend_vec[c]),
      .irq_q      (cpu_irq[c])
    );
  end

  always_comb begin
    case (sel_kind)
      SEL_MASK: rd_word = mask_vec[sel_cpu];
      SEL_PEND: rd_word = pend_vec[sel_cpu];
      SEL_RAW:  rd_word = raw_vec;
      default:  rd_word = '0;
    endcase
    rvalid_d = req_valid;
    rerr_d   = req_valid & acc_err;
    rdata_d  = (req_valid && !req_write && !acc_err) ? DATA_W'(rd_word) : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rvalid_d;
      rsp_err   <= rerr_d;
      rsp_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int MAX_CPUS    = 4,
  parameter int ACTIVE_CPUS = 4,
  parameter int NUM_LINES   = 64,
  parameter int DATA_W      = 64,
  localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               req_valid,
  input logic [1:0]                         req_size,
  input logic                               post_valid,
  input logic [LINE_W-1:0]                  post_line,
  input logic                               clr_valid,
  input logic [LINE_W-1:0]                  clr_line,
  input logic [NUM_LINES-1:0]               raw_vec,
  input logic [MAX_CPUS-1:0][NUM_LINES-1:0] mask_vec,
  input logic [MAX_CPUS-1:0]                cpu_irq,
  input logic                               rsp_valid,
  input logic                               rsp_err,
  input logic [DATA_W-1:0]                  rsp_rdata
);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid)); // R2

  AST_POST_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !(clr_valid && clr_line == post_line)) |=> raw_vec[$past(post_line)]); // R4

  AST_SPURIOUS_CLEAR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !post_valid && !raw_vec[clr_line]) |=> $stable(raw_vec)); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && post_valid && clr_line == post_line) |=> !raw_vec[$past(clr_line)]); // R6

  AST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd3) |=> (rsp_err && rsp_rdata == '0)); // R8

  for (genvar c = 0; c < MAX_CPUS; c++) begin : g_chk
    AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] == $past(|(mask_vec[c] & raw_vec))); // R7
    if (c >= ACTIVE_CPUS) begin : g_off
      AST_INACTIVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec[c] == '0) && !cpu_irq[c]); // R11
    end
  end

endmodule

bind irq_router irq_router_chk #(
  .MAX_CPUS    (MAX_CPUS),
  .ACTIVE_CPUS (ACTIVE_CPUS),
  .NUM_LINES   (NUM_LINES),
  .DATA_W      (DATA_W)
) u_irq_router_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_size   (req_size),
  .post_valid (post_valid),
  .post_line  (post_line),
  .clr_valid  (clr_valid),
  .clr_line   (clr_line),
  .raw_vec    (raw_vec),
  .mask_vec   (mask_vec),
  .cpu_irq    (cpu_irq),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;

  localparam int NCPU = 4;
  localparam int ACT  = 3;
  localparam int PEND0 = NCPU;
  localparam int RAWI  = 2 * NCPU;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        post_valid, clr_valid;
  logic [5:0]  post_line, clr_line;
  logic [3:0]  cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0] exp_raw;
  logic [63:0] exp_mask [NCPU];

  always #5 clk = ~clk;

  irq_router #(.MAX_CPUS(NCPU), .ACTIVE_CPUS(ACT)) u_irq_router (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .post_valid(post_valid), .post_line(post_line),
    .clr_valid(clr_valid), .clr_line(clr_line),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input int idx, input logic [5:0] low, input logic [1:0] sz,
                     input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {6'(idx), low};
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic rd_chk(input string tag, input int idx, input logic [63:0] exp);
    logic [63:0] rd; logic er;
    acc(1'b0, idx, 6'd0, 2'd3, 64'd0, rd, er);
    chk(tag, rd, exp);
    chk({tag, " err"}, {63'd0, er}, 64'd0);
  endtask

  task automatic wr_mask(input int c, input logic [63:0] v);
    logic [63:0] rd; logic er;
    acc(1'b1, c, 6'd0, 2'd3, v, rd, er);
    if (c < ACT) exp_mask[c] = v;
  endtask

  task automatic pulse(input bit p, input int pl, input bit q, input int ql);
    @(negedge clk);
    post_valid = p; post_line = 6'(pl); clr_valid = q; clr_line = 6'(ql);
    @(negedge clk);
    post_valid = 1'b0; clr_valid = 1'b0;
    if (p) exp_raw[pl] = 1'b1;
    if (q) exp_raw[ql] = 1'b0;
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] v = '0;
    for (int c = 0; c < ACT; c++) v[c] = |(exp_mask[c] & exp_raw);
    return v;
  endfunction

  task automatic irq_chk(input string tag);
    @(negedge clk);
    chk(tag, {60'd0, cpu_irq}, {60'd0, exp_irq()});
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {60'd0, cpu_irq}, 64'd0);
    chk("R1 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
    rd_chk("R1 raw zero", RAWI, 64'd0);
    rd_chk("R1 mask0 zero", 0, 64'd0);
    rd_chk("R1 pend0 zero", PEND0, 64'd0);
  endtask

  task automatic t_mask_rw();
    wr_mask(0, 64'h0000_0000_0000_00F0);
    wr_mask(1, 64'h8000_0000_0000_0010);
    wr_mask(2, 64'h0123_4567_89AB_CDEF);
    rd_chk("R2 mask0", 0, exp_mask[0]);
    rd_chk("R2 mask1", 1, exp_mask[1]);
    rd_chk("R2 mask2", 2, exp_mask[2]);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'd0; req_size = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid next cycle", {63'd0, rsp_valid}, 64'd1);
  endtask

  task automatic t_post_route();
    pulse(1'b1, 4, 1'b0, 0);
    irq_chk("R7 irq after post 4");
    pulse(1'b1, 63, 1'b0, 0);
    rd_chk("R4 raw after posts", RAWI, exp_raw);
    rd_chk("R3 pend0", PEND0, exp_mask[0] & exp_raw);
    rd_chk("R3 pend1", PEND0 + 1, exp_mask[1] & exp_raw);
    rd_chk("R3 pend2", PEND0 + 2, exp_mask[2] & exp_raw);
    irq_chk("R7 irq after post 63");
  endtask

  task automatic t_mask_toggle();
    wr_mask(0, 64'h0);
    irq_chk("R7 mask drops irq0");
    wr_mask(0, 64'h10);
    irq_chk("R7 unmask raises irq0");
    rd_chk("R3 pend0 after unmask", PEND0, 64'h10);
  endtask

  task automatic t_clear();
    pulse(1'b0, 0, 1'b1, 4);
    rd_chk("R5 clear line 4", RAWI, exp_raw);
    irq_chk("R7 irq after clear");
    pulse(1'b0, 0, 1'b1, 9);
    rd_chk("R5 spurious clear no change", RAWI, exp_raw);
  endtask

  task automatic t_same_cycle();
    pulse(1'b1, 7, 1'b1, 7);
    rd_chk("R6 clear wins same line", RAWI, exp_raw);
    pulse(1'b1, 20, 1'b1, 63);
    rd_chk("R6 different lines both apply", RAWI, exp_raw);
  endtask

  task automatic t_narrow();
    logic [63:0] rd; logic er;
    acc(1'b1, 1, 6'd0, 2'd2, 64'hFFFF, rd, er);
    chk("R8 narrow write err", {63'd0, er}, 64'd1);
    rd_chk("R8 mask1 unchanged", 1, exp_mask[1]);
    acc(1'b0, 2, 6'd0, 2'd0, 64'd0, rd, er);
    chk("R8 narrow read err", {63'd0, er}, 64'd1);
    chk("R8 narrow read data", rd, 64'd0);
  endtask

  task automatic t_illegal_write();
    logic [63:0] rd; logic er;
    acc(1'b1, PEND0, 6'd0, 2'd3, 64'hFFFF_FFFF, rd, er);
    chk("R9 pend write err", {63'd0, er}, 64'd1);
    acc(1'b1, RAWI, 6'd0, 2'd3, 64'hFFFF_FFFF, rd, er);
    chk("R9 raw write err", {63'd0, er}, 64'd1);
    rd_chk("R9 raw unchanged", RAWI, exp_raw);
    rd_chk("R9 mask0 unchanged", 0, exp_mask[0]);
  endtask

  task automatic t_unmapped();
    logic [63:0] rd; logic er;
    acc(1'b0, 20, 6'd0, 2'd3, 64'd0, rd, er);
    chk("R10 unmapped err", {63'd0, er}, 64'd1);
    chk("R10 unmapped data", rd, 64'd0);
    acc(1'b0, 0, 6'd8, 2'd3, 64'd0, rd, er);
    chk("R10 offset low bits err", {63'd0, er}, 64'd1);
    chk("R10 offset low bits data", rd, 64'd0);
  endtask

  task automatic t_inactive();
    logic [63:0] rd; logic er;
    acc(1'b1, 3, 6'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, er);
    chk("R11 inactive write no err", {63'd0, er}, 64'd0);
    rd_chk("R11 inactive mask reads 0", 3, 64'd0);
    pulse(1'b1, 33, 1'b0, 0);
    irq_chk("R11 inactive irq low");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; post_valid = 1'b0; clr_valid = 1'b0;
    post_line = '0; clr_line = '0;
    exp_raw = '0;
    for (int c = 0; c < NCPU; c++) exp_mask[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mask_rw();
    t_post_route();
    t_mask_toggle();
    t_clear();
    t_same_cycle();
    t_narrow();
    t_illegal_write();
    t_unmapped();
    t_inactive();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule